// File: doc/BRIEF.md
# Request-Driven Clock Output Gating

This block sits between a free-running source clock and a bank of differential reference clock outputs. Two active-low request inputs, A and B, let downstream devices ask for their clocks. Each output carries two configuration bits: one marks it as stoppable, and the other names the request that governs it. Outputs that are not stoppable run all the time. A stoppable output runs while its request is held low and parks once its request is withdrawn.

Each request pin crosses into the source clock domain through a two-flop synchronizer. The synchronized request drives a per-output enable latch, which is transparent only while the source clock is low. A stop or a restart therefore never cuts a high pulse short and never creates a runt pulse. A parked output drives its true pin low, drives its complement pin low and drops its drive-enable, so the pad releases both pins.

The block has no data stream, so no valid/ready handshake applies. Every pin is a plain level control.

Top module: `refclk_req_gate`

## Requirements
- R1: While rst_n is low, both synchronizer stages read as "no request". Every stoppable output is parked even if its request pin is low, and every non-stoppable output keeps toggling.
- R2: An output with its cfg_stop bit at 0 runs whatever the request pins do.
- R3: If a lane's request pin goes high before rising edge k, the lane still gives full high pulses after edges k and k+1. It is parked from the falling edge after k+1 onward. The gate changes only while the source clock is low.
- R4: A parked output has out_p = 0, out_n = 0 and out_oe = 0.
- R5: If a lane's request pin goes low before rising edge k, the parked lane stays low through edges k and k+1. Its first pulse starts at edge k+2, two periods later.
- R6: All stoppable lanes governed by the same request restart on the same rising edge and stop on the same falling edge.
- R7: cfg_sel_b bit 0 selects request A and bit 1 selects request B. The two requests act independently of each other.
- R8: Each request pin is active low and passes through a two-flop synchronizer clocked by the source clock. The synchronized value equals the inverted pin value from two rising edges earlier.
- R9: A running output has out_p equal to the source clock, out_n equal to its inverse, and out_oe = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset of the synchronizers |
| req_a_n | input | 1 | Request A, active low, asynchronous |
| req_b_n | input | 1 | Request B, active low, asynchronous |
| cfg_stop | input | NUM_OUT | Per-output stoppable flag (1 = may be parked) |
| cfg_sel_b | input | NUM_OUT | Per-output request select (0 = A, 1 = B) |
| out_p | output | NUM_OUT | Gated true clock |
| out_n | output | NUM_OUT | Gated complement clock |
| out_oe | output | NUM_OUT | Per-output drive enable for both pins |

## Verification
Assertions check on every rising edge that each output's enable matches the run decision formed from its configuration and its synchronized request. They also check that non-stoppable lanes stay enabled, that lanes with identical configuration agree, and that the synchronizer delays each request by exactly two edges. What only the bench can show is waveform shape at the pins: the count of edges between a request change and the first or last pulse, whether the final pulse is full width, the complement phase, and the pin levels of a parked lane.

// File: rtl/refclk_gate_pkg.sv
package refclk_gate_pkg;
  localparam int NUM_REQ = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    REQ_SEL_A = 1'b0,
    REQ_SEL_B = 1'b1
  } req_sel_e;

  function automatic logic lane_should_run(input logic stoppable,
                                           input req_sel_e sel,
                                           input logic [NUM_REQ-1:0] active);
    return !stoppable || active[sel];
  endfunction
endpackage

// File: rtl/refclk_req_sync.sv
module refclk_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic active
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], ~req_n};
  end

  assign active = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] primed_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            primed_q <= '0;
        else if (!primed_q[1]) primed_q <= primed_q + 2'd1;
      end
      // R8: the synchronized request lags the inverted pin by two edges
      p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q == 2'd2) |-> (active == $past(~req_n, 2)));
    end
  endgenerate
endmodule

// File: rtl/refclk_gate_lane.sv
module refclk_gate_lane (
  input  logic clk,
  input  logic run_req,
  output logic out_p,
  output logic out_n,
  output logic out_oe
);
  logic en_q;

  // Transparent only in the low phase, so a gate change never trims a pulse.
  always_latch begin
    if (!clk) en_q <= run_req;
  end

  assign out_p  = clk & en_q;
  assign out_n  = ~clk & en_q;
  assign out_oe = en_q;
endmodule

// File: rtl/refclk_req_gate.sv
module refclk_req_gate
  import refclk_gate_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               req_a_n,
  input  logic               req_b_n,
  input  logic [NUM_OUT-1:0] cfg_stop,
  input  logic [NUM_OUT-1:0] cfg_sel_b,
  output logic [NUM_OUT-1:0] out_p,
  output logic [NUM_OUT-1:0] out_n,
  output logic [NUM_OUT-1:0] out_oe
);
  logic [NUM_REQ-1:0] req_pin_n;
  logic [NUM_REQ-1:0] req_active;
  logic [NUM_OUT-1:0] lane_run;

  assign req_pin_n = {req_b_n, req_a_n};

  generate
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_sync
      refclk_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .req_n  (req_pin_n[r]),
        .active (req_active[r])
      );
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      assign lane_run[i] = lane_should_run(cfg_stop[i], req_sel_e'(cfg_sel_b[i]), req_active);

      refclk_gate_lane u_lane (
        .clk    (clk_src),
        .run_req(lane_run[i]),
        .out_p  (out_p[i]),
        .out_n  (out_n[i]),
        .out_oe (out_oe[i])
      );

      // R2: a lane that is not stoppable is always driving
      p_free_run_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
        !cfg_stop[i] |-> out_oe[i]);

      // R3: the latched enable seen at the edge equals the low-phase run decision
      p_gate_follows_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
        out_oe[i] == lane_run[i]);

      if (i > 0) begin : g_pair
        // R6: lanes with identical configuration switch together
        p_same_cycle_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
          (cfg_stop[i] == cfg_stop[i-1] && cfg_sel_b[i] == cfg_sel_b[i-1])
            |-> (out_oe[i] == out_oe[i-1]));
      end
    end
  endgenerate
endmodule

// File: tb/refclk_req_gate_tb.sv
module refclk_req_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  typedef struct packed {
    logic         a_n;
    logic         b_n;
    logic [N-1:0] exp_oe;
  } vec_t;

  // Lane 0 free-running; lanes 1 and 3 on A; lane 2 on B.
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 4'b0001},
    '{1'b0, 1'b1, 4'b1011},
    '{1'b1, 1'b0, 4'b0101},
    '{1'b0, 1'b0, 4'b1111},
    '{1'b1, 1'b1, 4'b0001},
    '{1'b0, 1'b0, 4'b1111},
    '{1'b0, 1'b1, 4'b1011},
    '{1'b1, 1'b1, 4'b0001}
  };

  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic req_a_n = 1'b1;
  logic req_b_n = 1'b1;
  logic [N-1:0] cfg_stop = 4'b1110;
  logic [N-1:0] cfg_sel_b = 4'b0100;
  logic [N-1:0] out_p, out_n, out_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  refclk_req_gate #(.NUM_OUT(N)) u_dut (
    .clk_src(clk_src), .rst_n(rst_n), .req_a_n(req_a_n), .req_b_n(req_b_n),
    .cfg_stop(cfg_stop), .cfg_sel_b(cfg_sel_b),
    .out_p(out_p), .out_n(out_n), .out_oe(out_oe)
  );

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_slot();   // just after a falling edge
    @(negedge clk_src); #1;
  endtask
  task automatic high_sample();  // inside the high phase
    @(posedge clk_src); #2;
  endtask
  task automatic low_sample();   // inside the low phase
    @(negedge clk_src); #2;
  endtask

  initial begin
    // R1: reset holds stoppable lanes parked despite low request pins
    req_a_n = 1'b0; req_b_n = 1'b0;
    repeat (3) high_sample();
    chk("R1 oe in reset", out_oe, 4'b0001);
    chk("R1 free lane high phase", out_p, 4'b0001);
    low_sample();
    chk("R1 parked pins low", out_n, 4'b0001);

    drive_slot(); rst_n = 1'b1;
    repeat (3) high_sample();
    chk("R1 lanes run after release", out_oe, 4'b1111);

    drive_slot(); req_a_n = 1'b1; req_b_n = 1'b1;
    repeat (3) high_sample();

    // R7 R9 R4 R2: vector table
    foreach (VECS[v]) begin
      drive_slot();
      req_a_n = VECS[v].a_n;
      req_b_n = VECS[v].b_n;
      repeat (3) high_sample();
      chk($sformatf("R7 oe vec%0d", v), out_oe, VECS[v].exp_oe);
      chk($sformatf("R9 p high vec%0d", v), out_p, VECS[v].exp_oe);
      low_sample();
      chk($sformatf("R4 n low-phase vec%0d", v), {out_n, out_p}, {VECS[v].exp_oe, 4'b0000});
    end

    // R5 R6 R8: restart latency, two-period resume, same-edge start
    drive_slot(); req_a_n = 1'b0;
    high_sample(); chk("R8 edge k still parked", out_p[1], 1'b0);
    high_sample(); chk("R5 edge k+1 still parked", {out_p[3], out_p[1]}, 2'b00);
    high_sample(); chk("R6 edge k+2 both start", {out_p[3], out_p[1]}, 2'b11);

    // R3 R4: stop after full final pulse
    drive_slot(); req_a_n = 1'b1;
    high_sample(); chk("R3 pulse after edge k", out_p[1], 1'b1);
    high_sample(); chk("R3 full last pulse k+1", out_p[1], 1'b1);
    low_sample();
    chk("R4 parked pins", {out_oe[1], out_n[1], out_p[1]}, 3'b000);
    chk("R6 same-request lanes park together", {out_oe[3], out_oe[1]}, 2'b00);
    chk("R2 free lane unaffected", {out_oe[0], out_n[0]}, 2'b11);
    high_sample(); chk("R3 no pulse at k+2", out_p[1], 1'b0);

    // R7: moving lane 1 to request B while only A is asserted parks it
    drive_slot(); req_a_n = 1'b0;
    repeat (3) high_sample();
    drive_slot(); cfg_sel_b[1] = 1'b1;
    high_sample();
    chk("R7 lane1 follows B", {out_oe[3], out_oe[1]}, 2'b10);

    // R2: clearing stoppable on a parked lane makes it run
    drive_slot(); cfg_stop[1] = 1'b0;
    high_sample();
    chk("R2 non-stoppable runs", out_p[1], 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule